// File: doc/BRIEF.md
# Serial Transmitter with Holding Register

This block serializes bytes onto an asynchronous serial line. A byte written through a strobe lands in a one-byte holding register, and from there it moves into a shift register. The shift register sends a low start bit, then 5 to 8 data bits with the least significant bit first. An optional parity bit follows, and then 1, 1.5 or 2 stop bits. Bit timing comes from an external tick that pulses at twice the bit rate, so every bit lasts two ticks. The half-bit stop length is a three-tick stop period.

A frame starts only under these conditions:
- the shifter is idle,
- a byte is waiting,
- the clear-to-send input is high,
- either the live transmit enable or the enable value captured at the write is set.

Software watches two ready flags. `readyStart` reports that the queued byte has left the holding register and its start bit has gone out, so one more byte may be queued. `readyDone` reports that the last written byte has fully left the line. An interrupt request follows the two flags when it is enabled. A control input inverts the line level during idle and during stop bits.

Top module: `uartTxHold`

## Requirements
- R1: After a synchronous reset:
  - `txOut` sits at the idle level (`~invIdle`),
  - `readyStart` and `readyDone` are both 1,
  - no byte is pending,
  - the captured enable is 0.
- R2: A frame has the following shape on the line. Every bit is held for exactly two `halfTick` pulses.
  - It begins with a start bit at level 0. This bit is driven in the cycle after the frame is accepted.
  - The data bits follow, least significant bit first.
- R3: `charLen` codes 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits (the low bits of the byte). These codes are sampled when the frame starts.
- R4: With `parEn`=1, a parity bit follows the data bits. It is computed over the sent data bits only. With `parOdd`=0 the total count of ones is even; with `parOdd`=1 it is odd. With `parEn`=0 no parity bit is sent.
- R5: The length of the stop period is set by `stopSel`:
  - codes 0 and 1 give 2 `halfTick` pulses (one bit),
  - code 2 gives 3 pulses (1.5 bits),
  - code 3 gives 4 pulses (two bits).
- R6: A pending byte starts only when the shifter is idle, `ctsIn` is 1, and either the live `txEn` or the captured enable is 1. Until then it waits, and the line stays at the idle level.
- R7: Each `wrStb` captures the live `txEn`. If `txEn` is cleared after the write, the pending byte still starts once `ctsIn` is 1.
- R8: A `wrStb` clears both ready flags in the next cycle. A write made while a byte is pending and not yet started replaces that byte, and only the newer byte is sent.
- R9: `readyStart` becomes 1 at the end of a start bit, but only if no newer byte is pending at that moment.
- R10: `readyDone` becomes 1 at the end of the last stop half-bit, but only if no newer byte is pending.
- R11: When `invIdle`=1, the line is driven low while idle and during stop bits. The start, data and parity bits are unaffected.
- R12: `txIrq` is 1 exactly when `txIrqEn` is 1 and at least one of the ready flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStb | input | 1 | Data write strobe |
| wrData | input | DATA_W | Byte to send |
| charLen | input | 2 | Data bit count code (5 + code) |
| parEn | input | 1 | Parity bit enable |
| parOdd | input | 1 | Parity type, 0 even, 1 odd |
| stopSel | input | 2 | Stop length code |
| txEn | input | 1 | Live transmit enable |
| invIdle | input | 1 | Invert idle and stop level |
| txIrqEn | input | 1 | Interrupt enable |
| ctsIn | input | 1 | Clear-to-send from the far end |
| halfTick | input | 1 | Tick at twice the bit rate |
| txOut | output | 1 | Serial line |
| readyStart | output | 1 | Ready flag: queued byte has started |
| readyDone | output | 1 | Ready flag: last byte has finished |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its default `DATA_W` of 8. This width brings all four character lengths, both parity types and all four stop codes within reach. A sweep runs through every combination of these modes with random data bytes.

The `halfTick` pulses arrive at irregular intervals. This exposes any miscount between ticks and bit boundaries.

Directed sequences cover three further cases:
- a write held off by clear-to-send,
- an enable withdrawn after the write,
- bytes queued during a frame's start bit and during its later bits.

Together these test the replacement rule and the conditions under which each flag is withheld.

// File: rtl/uartTxPkg.sv
package uartTxPkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_t;

  typedef struct packed {
    logic   load;   // move holding byte into the shifter
    logic   shift;  // a data bit has finished
    phase_t phase;  // what the line carries now
  } txStrobe_t;
endpackage

// File: rtl/uartTxData.sv
module uartTxData
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        charLen,
  input  logic              parOdd,
  input  logic              invIdle,
  input  txStrobe_t         strb,
  output logic              txOut
);
  localparam int MIN_BITS = 5;

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              parBit;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      lenMask[i] = (i < MIN_BITS + int'(charLen));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.load) begin
        shiftReg <= holdData;
        parBit   <= (^(holdData & lenMask)) ^ parOdd;
      end else if (strb.shift) begin
        shiftReg <= shiftReg >> 1;
      end
      if (wrStb) begin
        holdData <= wrData;
      end
    end
  end

  always_comb begin
    unique case (strb.phase)
      PH_START:  txOut = 1'b0;
      PH_DATA:   txOut = shiftReg[0];
      PH_PARITY: txOut = parBit;
      default:   txOut = ~invIdle;
    endcase
  end
endmodule

// File: rtl/uartTxCtrl.sv
module uartTxCtrl
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wrStb,
  input  logic [1:0] charLen,
  input  logic      parEn,
  input  logic [1:0] stopSel,
  input  logic      txEn,
  input  logic      ctsIn,
  input  logic      halfTick,
  output txStrobe_t strb,
  output logic      readyStart,
  output logic      readyDone
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = 3;

  phase_t           phase;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] needHalves;
  logic [CNT_W-1:0] frmHalves;
  logic [CNT_W-1:0] stopHalves;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] frmLast;
  logic [IDX_W-1:0] lastIdx;
  logic             frmPar;
  logic             holdValid;
  logic             latchedEn;
  logic             canLoad;
  logic             bitEnd;

  always_comb begin
    unique case (stopSel)
      2'd2:    stopHalves = CNT_W'(3);
      2'd3:    stopHalves = CNT_W'(4);
      default: stopHalves = CNT_W'(2);
    endcase
    lastIdx    = IDX_W'(4) + IDX_W'(charLen);
    needHalves = (phase == PH_STOP) ? frmHalves : CNT_W'(2);
    canLoad    = (phase == PH_IDLE) && holdValid && ctsIn && (txEn || latchedEn);
    bitEnd     = (phase != PH_IDLE) && halfTick && (halfCnt == needHalves - CNT_W'(1));
    strb.load  = canLoad;
    strb.shift = bitEnd && (phase == PH_DATA);
    strb.phase = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      halfCnt    <= '0;
      bitIdx     <= '0;
      frmLast    <= '0;
      frmPar     <= 1'b0;
      frmHalves  <= CNT_W'(2);
      holdValid  <= 1'b0;
      latchedEn  <= 1'b0;
      readyStart <= 1'b1;
      readyDone  <= 1'b1;
    end else begin
      if (canLoad) begin
        phase     <= PH_START;
        halfCnt   <= '0;
        frmLast   <= lastIdx;
        frmPar    <= parEn;
        frmHalves <= stopHalves;
      end else if (bitEnd) begin
        halfCnt <= '0;
        unique case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            bitIdx <= '0;
            if (!holdValid) readyStart <= 1'b1;
          end
          PH_DATA: begin
            if (bitIdx == frmLast) phase <= frmPar ? PH_PARITY : PH_STOP;
            else                   bitIdx <= bitIdx + IDX_W'(1);
          end
          PH_PARITY: phase <= PH_STOP;
          PH_STOP: begin
            phase <= PH_IDLE;
            if (!holdValid) readyDone <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end else if (phase != PH_IDLE && halfTick) begin
        halfCnt <= halfCnt + CNT_W'(1);
      end

      if (wrStb) begin
        holdValid  <= 1'b1;
        latchedEn  <= txEn;
        readyStart <= 1'b0;
        readyDone  <= 1'b0;
      end else if (canLoad) begin
        holdValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uartTxHold.sv
module uartTxHold
  import uartTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        charLen,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic [1:0]        stopSel,
  input  logic              txEn,
  input  logic              invIdle,
  input  logic              txIrqEn,
  input  logic              ctsIn,
  input  logic              halfTick,
  output logic              txOut,
  output logic              readyStart,
  output logic              readyDone,
  output logic              txIrq
);
  txStrobe_t strb;

  uartTxCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrStb      (wrStb),
    .charLen    (charLen),
    .parEn      (parEn),
    .stopSel    (stopSel),
    .txEn       (txEn),
    .ctsIn      (ctsIn),
    .halfTick   (halfTick),
    .strb       (strb),
    .readyStart (readyStart),
    .readyDone  (readyDone)
  );

  uartTxData #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst     (rst),
    .wrStb   (wrStb),
    .wrData  (wrData),
    .charLen (charLen),
    .parOdd  (parOdd),
    .invIdle (invIdle),
    .strb    (strb),
    .txOut   (txOut)
  );

  assign txIrq = txIrqEn && (readyStart || readyDone);
endmodule

// File: rtl/uartTxHoldChk.sv
module uartTxHoldChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wrStb,
  input logic [DATA_W-1:0] wrData,
  input logic [1:0]        charLen,
  input logic              parEn,
  input logic              parOdd,
  input logic [1:0]        stopSel,
  input logic              txEn,
  input logic              invIdle,
  input logic              txIrqEn,
  input logic              ctsIn,
  input logic              halfTick,
  input logic              txOut,
  input logic              readyStart,
  input logic              readyDone,
  input logic              txIrq
);
  a_r1_flags_after_reset: assert property (@(posedge clk)
    $past(rst) && !rst |-> readyStart && readyDone);

  a_r8_write_clears_flags: assert property (@(posedge clk) disable iff (rst)
    wrStb |=> !readyStart && !readyDone);

  a_r10_done_implies_started: assert property (@(posedge clk) disable iff (rst)
    readyDone |-> readyStart);

  a_r11_done_line_idle: assert property (@(posedge clk) disable iff (rst)
    readyDone |-> txOut == !invIdle);

  a_r6_no_start_without_cts: assert property (@(posedge clk) disable iff (rst)
    readyDone && !ctsIn |=> txOut == !invIdle);

  a_r12_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !txIrqEn |-> !txIrq);

  a_r12_irq_on_done: assert property (@(posedge clk) disable iff (rst)
    txIrqEn && readyDone |-> txIrq);
endmodule

bind uartTxHold uartTxHoldChk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_uartTxHold.sv
`timescale 1ns/1ps
module test_uartTxHold;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] charLen = 2'd3;
  logic       parEn = 1'b0;
  logic       parOdd = 1'b0;
  logic [1:0] stopSel = 2'd1;
  logic       txEn = 1'b1;
  logic       invIdle = 1'b0;
  logic       txIrqEn = 1'b0;
  logic       ctsIn = 1'b1;
  logic       halfTick = 1'b0;
  logic       txOut, readyStart, readyDone, txIrq;

  int vecs = 0;
  int errs = 0;
  int cycles = 0;
  bit tickAuto = 1'b1;

  always #2.5 clk = ~clk;

  uartTxHold i_uartTxHold (
    .clk(clk), .rst(rst), .wrStb(wrStb), .wrData(wrData), .charLen(charLen),
    .parEn(parEn), .parOdd(parOdd), .stopSel(stopSel), .txEn(txEn),
    .invIdle(invIdle), .txIrqEn(txIrqEn), .ctsIn(ctsIn), .halfTick(halfTick),
    .txOut(txOut), .readyStart(readyStart), .readyDone(readyDone), .txIrq(txIrq)
  );

  // ---------------- behavioural reference ----------------
  // Queue of half-bit line levels; value 2 stands for the idle/stop level.
  logic [1:0] mq[$];
  int         mPopped;
  bit         mHoldV, mLatEn, mFs, mFd;
  logic [7:0] mHold;

  always @(posedge clk) begin
    bit active;
    int n;
    logic [7:0] masked;
    if (rst) begin
      mq.delete();
      mPopped = 0; mHoldV = 0; mLatEn = 0; mFs = 1; mFd = 1; mHold = '0;
    end else begin
      active = (mq.size() > 0);
      if (active) begin
        if (halfTick) begin
          void'(mq.pop_front());
          mPopped++;
          if (mPopped == 2) mFs = !mHoldV;
          if (mq.size() == 0) mFd = !mHoldV;
        end
      end else if (mHoldV && ctsIn && (txEn || mLatEn)) begin
        n = 5 + int'(charLen);
        masked = '0;
        mq.push_back(2'd0); mq.push_back(2'd0);
        for (int i = 0; i < n; i++) begin
          masked[i] = mHold[i];
          mq.push_back({1'b0, mHold[i]}); mq.push_back({1'b0, mHold[i]});
        end
        if (parEn) begin
          mq.push_back({1'b0, (^masked) ^ parOdd});
          mq.push_back({1'b0, (^masked) ^ parOdd});
        end
        n = (stopSel == 2'd2) ? 3 : (stopSel == 2'd3) ? 4 : 2;
        for (int i = 0; i < n; i++) mq.push_back(2'd2);
        mHoldV = 0;
        mPopped = 0;
      end
      if (wrStb) begin
        mHold = wrData; mHoldV = 1; mLatEn = txEn; mFs = 0; mFd = 0;
      end
    end
  end

  function automatic logic expLine();
    if (mq.size() == 0 || mq[0] == 2'd2) return !invIdle;
    return mq[0][0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(txOut == expLine(), "R2/R3/R4/R5/R8/R11 line", txOut, expLine());
      chk(readyStart == mFs, "R9 readyStart", readyStart, mFs);
      chk(readyDone == mFd, "R10 readyDone", readyDone, mFd);
      chk(txIrq == (txIrqEn && (mFs || mFd)), "R12 txIrq", txIrq, txIrqEn && (mFs || mFd));
    end
  end

  // Irregular tick source, driven after the falling edge
  always @(negedge clk) begin
    #1;
    halfTick = tickAuto && (($urandom % 3) == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      errs++;
      vecs++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrData = d; wrStb = 1'b1;
    step(1);
    wrStb = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000; i++) begin
      if (readyDone) break;
      step(1);
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(txOut == 1'b1, "R1 idle line", txOut, 1);
    chk(readyStart && readyDone, "R1 flags", {readyStart, readyDone}, 3);
    #1;

    // Basic 8N1 frame
    writeByte(8'hA5);
    @(negedge clk);
    chk(!readyStart && !readyDone, "R8 write clears flags", {readyStart, readyDone}, 0);
    #1;
    // start bit appears the cycle after acceptance (accept cycle was write+1)
    step(0);
    @(negedge clk);
    chk(txOut == 1'b0, "R2 start bit low", txOut, 0);
    #1;
    waitDone();
    chk(readyDone == 1'b1, "R10 done after frame", readyDone, 1);

    // Mode sweep: length x parity x stop
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 3; p++) begin
        for (int s = 0; s < 4; s++) begin
          charLen = 2'(l); parEn = (p != 0); parOdd = (p == 2); stopSel = 2'(s);
          writeByte(8'($urandom));
          step(1);
          waitDone();
          chk(readyDone, "R3/R4/R5 frame completes", readyDone, 1);
        end
      end
    end
    charLen = 2'd3; parEn = 1'b0; stopSel = 2'd1;

    // R6: held off by CTS
    ctsIn = 1'b0;
    writeByte(8'h3C);
    step(40);
    chk(txOut == 1'b1 && !readyDone, "R6 waits for CTS", {txOut, readyDone}, 2);
    // R8: replace pending byte
    writeByte(8'hC3);
    step(5);
    ctsIn = 1'b1;
    step(2);
    chk(readyStart == 1'b0, "R9 not set before start bit ends", readyStart, 0);
    waitDone();
    chk(readyDone, "R8 replaced byte sent", readyDone, 1);

    // R6: txEn low at write and live -> waits
    txEn = 1'b0;
    writeByte(8'h5A);
    step(40);
    chk(txOut == 1'b1 && !readyDone, "R6 waits for enable", {txOut, readyDone}, 2);
    txEn = 1'b1;
    waitDone();
    chk(readyDone, "R6 starts after enable", readyDone, 1);

    // R7: enable captured at write, then cleared
    ctsIn = 1'b0;
    writeByte(8'h81);
    txEn = 1'b0;
    step(10);
    ctsIn = 1'b1;
    waitDone();
    chk(readyDone, "R7 latched enable sends byte", readyDone, 1);
    txEn = 1'b1;

    // Back-to-back: queue during start bit and after readyStart
    writeByte(8'h0F);
    step(2);
    writeByte(8'hF0);
    for (int i = 0; i < 2000 && !readyStart; i++) step(1);
    chk(readyStart, "R9 set by second byte", readyStart, 1);
    writeByte(8'h66);
    waitDone();
    chk(readyDone, "R10 done after queue drains", readyDone, 1);

    // R11: inverted idle
    invIdle = 1'b1;
    step(1);
    chk(txOut == 1'b0, "R11 inverted idle", txOut, 0);
    stopSel = 2'd3; parEn = 1'b1;
    writeByte(8'h99);
    waitDone();
    invIdle = 1'b0;

    // R12: interrupt enable
    txIrqEn = 1'b1;
    step(1);
    chk(txIrq == 1'b1, "R12 irq when ready", txIrq, 1);
    writeByte(8'h42);
    step(1);
    chk(txIrq == 1'b0, "R12 irq low after write", txIrq, 0);
    waitDone();
    step(1);
    chk(txIrq == 1'b1, "R12 irq after done", txIrq, 1);

    // R1: reset mid-frame
    writeByte(8'h00);
    step(6);
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    @(negedge clk);
    chk(readyStart && readyDone && txOut, "R1 reset mid-frame", {readyStart, readyDone, txOut}, 7);
    #1;
    step(20);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule